// File: doc/BRIEF.md
# Split-Transaction Read Requester with Two-Tag Tracking

This block sits between a DWord-oriented upstream packet interface and a split-transaction parallel bus on which it acts as bus master. Each upstream read request (address, length in DWords, command) is turned into one or two bus request phases. Each phase carries a byte count and a transaction tag. Only two tags exist, so at most two bus requests are outstanding at any time. When both are in use, the upstream side is held off through its ready signal.

A bus burst never runs past a 4-Kbyte page end. If an upstream request would run past one, it is split into a piece that ends exactly at the page end and a second piece that starts there. The crossing is also flagged, since upstream traffic is never expected to cross a page. Returning split completions are matched against the bridge's own requester ID and the outstanding tags. A completion with a matching ID and a live tag is forwarded upstream and retires its tag on its final beat. A completion with a matching ID and a dead tag is still claimed with device-select, but its data is dropped. A completion with a foreign ID is left alone.

The request side is a three-state machine:
- ST_IDLE accepts a request while a tag is free (IDLE→ISSUE).
- ST_ISSUE drives the first piece. It returns to idle when the request fits in the page (ISSUE→IDLE) and moves to hold when it was split (ISSUE→HOLD).
- ST_HOLD drives the second piece as soon as a tag is free (HOLD→IDLE) and waits otherwise (HOLD→HOLD).

Top module: `sptag_tracker`

## Requirements
- R1: After reset both tags are free, `up_ready` is 1, and `rq_valid`, `up_cross_err`, `cp_devsel`, `cd_valid` and `rt_valid` are all 0.
- R2: `up_ready` is 1 only in ST_IDLE while at least one tag is free. It is 0 while both tags are outstanding.
- R3: A request accepted at a clock edge shows its first bus request on `rq_valid` for exactly one cycle after that edge. The byte count `rq_bytes` is 4 × `up_len`, and `up_len` = 0 encodes 1024 DWords (4096 bytes).
- R4: A bus request takes the lowest-numbered free tag (tag 0 before tag 1). The tag is driven on `rq_tag`.
- R5: No bus request crosses a 4-Kbyte boundary. Let R = 4096 − (address mod 4096). A request of B > R bytes is issued as R bytes at its own address, then B − R bytes at address + R. The second piece appears in the next cycle if a tag is free, or in the cycle after the edge that frees one. A request with B ≤ R is issued once, unchanged.
- R6: `up_cross_err` is 1 in the same cycle as the first piece of a split request, and 0 for requests that fit.
- R7: A completion beat with `cp_id` equal to `own_id` and `cp_tag` naming an outstanding tag gives `cp_devsel`=1 and `cd_valid`=1 one cycle later, with `cd_tag` and `cd_data` equal to the beat's tag and data.
- R8: A completion beat with a matching ID but a tag that is not outstanding gives `cp_devsel`=1 one cycle later, with `cd_valid`=0 and `rt_valid`=0. It leaves the tag state unchanged.
- R9: A completion beat whose `cp_id` differs from `own_id` gives `cp_devsel`=0 and `cd_valid`=0 one cycle later.
- R10: An accepted beat whose remaining byte count `cp_bytes` is at most 4 is the last one. One cycle later `rt_valid`=1 with `rt_tag` equal to the beat's tag, and that tag is free from then on. An accepted beat with `cp_bytes` > 4 does not retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_id | input | ID_W | Bridge's requester ID |
| up_valid | input | 1 | Upstream request present |
| up_ready | output | 1 | Upstream request accepted when high with up_valid |
| up_addr | input | ADDR_W | Request byte address (DWord aligned) |
| up_len | input | PAGE_W-2 | Length in DWords, 0 means 1024 |
| up_cmd | input | CMD_W | Bus command to issue |
| up_cross_err | output | 1 | Request crossed a 4-Kbyte page |
| rq_valid | output | 1 | Bus request phase |
| rq_addr | output | ADDR_W | Bus request address |
| rq_bytes | output | PAGE_W+1 | Bus request byte count |
| rq_tag | output | TAG_W | Tag of this request |
| rq_cmd | output | CMD_W | Bus command |
| cp_valid | input | 1 | Completion beat present |
| cp_id | input | ID_W | Completion requester ID |
| cp_tag | input | TAG_W | Completion tag |
| cp_bytes | input | PAGE_W+1 | Remaining byte count, including this beat |
| cp_data | input | DATA_W | Completion data |
| cp_devsel | output | 1 | Completion claimed |
| cd_valid | output | 1 | Completion data forwarded |
| cd_tag | output | TAG_W | Tag of forwarded data |
| cd_data | output | DATA_W | Forwarded data |
| rt_valid | output | 1 | Tag retired |
| rt_tag | output | TAG_W | Retired tag |

## Verification
The bench sweeps page offsets, from the page start to the last DWord, against lengths from one DWord to the full 1024-DWord encoding. The expected pieces come from the page arithmetic. A design with an off-by-one in the remaining room would issue a burst that overruns the page or leaves a spurious zero-length tail, and a design that decodes zero-length wrongly would report 0 bytes. Directed cases fill both tags and check for stalling, hold a split second piece until a retire frees a tag, and return completions with a stale tag or a foreign ID. A design that skips the stale-tag claim, forwards the dropped data or ignores the ID compare fails on `cp_devsel` or `cd_valid`. Multi-beat completions check that only the final beat retires and that the freed tag is handed out again lowest-first.

// File: rtl/sptag_pkg.sv
package sptag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } iss_state_e;

endpackage

// File: rtl/sptag_tag_table.sv
module sptag_tag_table #(
    parameter int NUM_TAGS = 2,
    parameter int TAG_W    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_req,
    input  logic                free_v,
    input  logic [TAG_W-1:0]    free_tag,
    output logic [NUM_TAGS-1:0] busy,
    output logic                any_free,
    output logic [TAG_W-1:0]    alloc_tag
);

    // lowest free tag wins
    always_comb begin
        alloc_tag = '0;
        any_free  = 1'b0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                alloc_tag = TAG_W'(i);
                any_free  = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                busy[g] <= 1'b0;
            end else if (alloc_req && alloc_tag == TAG_W'(g)) begin
                busy[g] <= 1'b1;
            end else if (free_v && free_tag == TAG_W'(g)) begin
                busy[g] <= 1'b0;
            end
        end
    end

    AST_ALLOC_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> any_free);  // R2
    AST_ALLOC_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |=> busy[$past(alloc_tag)]);  // R4
    AST_FREE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        free_v |-> busy[free_tag]);  // R10

endmodule

// File: rtl/sptag_issue_fsm.sv
module sptag_issue_fsm
    import sptag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12,
    parameter int CMD_W  = 4,
    localparam int LEN_W = PAGE_W - 2,
    localparam int BC_W  = PAGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_free,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [LEN_W-1:0]  up_len,
    input  logic [CMD_W-1:0]  up_cmd,
    output logic              up_cross_err,
    output logic              rq_valid,
    output logic [ADDR_W-1:0] rq_addr,
    output logic [BC_W-1:0]   rq_bytes,
    output logic [CMD_W-1:0]  rq_cmd
);

    localparam logic [BC_W-1:0] PAGE_BYTES = BC_W'(1) << PAGE_W;

    iss_state_e        state, state_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic [BC_W-1:0]   cur_bytes;
    logic [CMD_W-1:0]  cur_cmd;
    logic [BC_W-1:0]   len_bytes;
    logic [BC_W-1:0]   room;
    logic              split;
    logic              accept;

    always_comb begin
        len_bytes = (up_len == '0) ? PAGE_BYTES : {1'b0, up_len, 2'b00};
        room      = PAGE_BYTES - BC_W'(cur_addr[PAGE_W-1:0]);
        split     = cur_bytes > room;
        accept    = up_valid && up_ready;
    end

    // state and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            cur_bytes <= '0;
            cur_cmd   <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cur_addr  <= up_addr;
                cur_bytes <= len_bytes;
                cur_cmd   <= up_cmd;
            end else if (state == ST_ISSUE && split) begin
                cur_addr  <= cur_addr + ADDR_W'(room);
                cur_bytes <= cur_bytes - room;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (up_valid && any_free) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = split ? ST_HOLD : ST_IDLE;
            ST_HOLD:  if (any_free) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        up_ready     = 1'b0;
        up_cross_err = 1'b0;
        rq_valid     = 1'b0;
        rq_addr      = cur_addr;
        rq_bytes     = cur_bytes;
        rq_cmd       = cur_cmd;
        unique case (state)
            ST_IDLE:  up_ready = any_free;
            ST_ISSUE: begin
                rq_valid     = 1'b1;
                up_cross_err = split;
                if (split) rq_bytes = room;
            end
            ST_HOLD:  rq_valid = any_free;
            default:  ;
        endcase
    end

    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |-> ((BC_W+1)'(rq_addr[PAGE_W-1:0]) + (BC_W+1)'(rq_bytes)
                      <= (BC_W+1)'(PAGE_BYTES)));  // R5
    AST_BYTES_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |-> rq_bytes != '0);  // R3
    AST_ERR_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        up_cross_err |-> rq_valid);  // R6
    AST_ACCEPT_THEN_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> rq_valid);  // R3

endmodule

// File: rtl/sptag_cpl_match.sv
module sptag_cpl_match #(
    parameter int ID_W     = 16,
    parameter int TAG_W    = 1,
    parameter int NUM_TAGS = 2,
    parameter int BC_W     = 13,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ID_W-1:0]     own_id,
    input  logic [NUM_TAGS-1:0] busy,
    input  logic                cp_valid,
    input  logic [ID_W-1:0]     cp_id,
    input  logic [TAG_W-1:0]    cp_tag,
    input  logic [BC_W-1:0]     cp_bytes,
    input  logic [DATA_W-1:0]   cp_data,
    output logic                free_v,
    output logic [TAG_W-1:0]    free_tag,
    output logic                cp_devsel,
    output logic                cd_valid,
    output logic [TAG_W-1:0]    cd_tag,
    output logic [DATA_W-1:0]   cd_data,
    output logic                rt_valid,
    output logic [TAG_W-1:0]    rt_tag
);

    logic id_hit;
    logic take;
    logic last_beat;

    always_comb begin
        id_hit    = cp_valid && (cp_id == own_id);
        take      = id_hit && busy[cp_tag];
        last_beat = cp_bytes <= BC_W'(4);
        free_v    = take && last_beat;
        free_tag  = cp_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cp_devsel <= 1'b0;
            cd_valid  <= 1'b0;
            cd_tag    <= '0;
            cd_data   <= '0;
            rt_valid  <= 1'b0;
            rt_tag    <= '0;
        end else begin
            cp_devsel <= id_hit;
            cd_valid  <= take;
            rt_valid  <= free_v;
            if (take) begin
                cd_tag  <= cp_tag;
                cd_data <= cp_data;
                rt_tag  <= cp_tag;
            end
        end
    end

    AST_DATA_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        cd_valid |-> cp_devsel);  // R7
    AST_RETIRE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid |-> cd_valid);  // R10
    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && cp_id != own_id) |=> !cp_devsel);  // R9
    AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && !busy[cp_tag]) |=> !cd_valid);  // R8

endmodule

// File: rtl/sptag_tracker.sv
module sptag_tracker #(
    parameter int ADDR_W   = 32,
    parameter int PAGE_W   = 12,
    parameter int CMD_W    = 4,
    parameter int ID_W     = 16,
    parameter int DATA_W   = 32,
    parameter int NUM_TAGS = 2,
    localparam int LEN_W   = PAGE_W - 2,
    localparam int BC_W    = PAGE_W + 1,
    localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   own_id,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [LEN_W-1:0]  up_len,
    input  logic [CMD_W-1:0]  up_cmd,
    output logic              up_cross_err,
    output logic              rq_valid,
    output logic [ADDR_W-1:0] rq_addr,
    output logic [BC_W-1:0]   rq_bytes,
    output logic [TAG_W-1:0]  rq_tag,
    output logic [CMD_W-1:0]  rq_cmd,
    input  logic              cp_valid,
    input  logic [ID_W-1:0]   cp_id,
    input  logic [TAG_W-1:0]  cp_tag,
    input  logic [BC_W-1:0]   cp_bytes,
    input  logic [DATA_W-1:0] cp_data,
    output logic              cp_devsel,
    output logic              cd_valid,
    output logic [TAG_W-1:0]  cd_tag,
    output logic [DATA_W-1:0] cd_data,
    output logic              rt_valid,
    output logic [TAG_W-1:0]  rt_tag
);

    logic [NUM_TAGS-1:0] busy;
    logic                any_free;
    logic                free_v;
    logic [TAG_W-1:0]    free_tag;

    sptag_issue_fsm #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .CMD_W  (CMD_W)
    ) u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_free     (any_free),
        .up_valid     (up_valid),
        .up_ready     (up_ready),
        .up_addr      (up_addr),
        .up_len       (up_len),
        .up_cmd       (up_cmd),
        .up_cross_err (up_cross_err),
        .rq_valid     (rq_valid),
        .rq_addr      (rq_addr),
        .rq_bytes     (rq_bytes),
        .rq_cmd       (rq_cmd)
    );

    sptag_tag_table #(
        .NUM_TAGS (NUM_TAGS),
        .TAG_W    (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (rq_valid),
        .free_v    (free_v),
        .free_tag  (free_tag),
        .busy      (busy),
        .any_free  (any_free),
        .alloc_tag (rq_tag)
    );

    sptag_cpl_match #(
        .ID_W     (ID_W),
        .TAG_W    (TAG_W),
        .NUM_TAGS (NUM_TAGS),
        .BC_W     (BC_W),
        .DATA_W   (DATA_W)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_id    (own_id),
        .busy      (busy),
        .cp_valid  (cp_valid),
        .cp_id     (cp_id),
        .cp_tag    (cp_tag),
        .cp_bytes  (cp_bytes),
        .cp_data   (cp_data),
        .free_v    (free_v),
        .free_tag  (free_tag),
        .cp_devsel (cp_devsel),
        .cd_valid  (cd_valid),
        .cd_tag    (cd_tag),
        .cd_data   (cd_data),
        .rt_valid  (rt_valid),
        .rt_tag    (rt_tag)
    );

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> !up_ready);  // R2
    AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid |-> !busy[rt_tag]);  // R10

endmodule

// File: tb/sptag_tracker_tb.sv
`timescale 1ns/1ps
module sptag_tracker_tb_top;

    localparam int ADDR_W = 32;
    localparam int BC_W   = 13;
    localparam logic [15:0] MY_ID    = 16'h0A5C;
    localparam logic [15:0] OTHER_ID = 16'h0A5D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] own_id = MY_ID;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic [31:0] up_addr = '0;
    logic [9:0]  up_len = '0;
    logic [3:0]  up_cmd = 4'h6;
    logic        up_cross_err;
    logic        rq_valid;
    logic [31:0] rq_addr;
    logic [12:0] rq_bytes;
    logic        rq_tag;
    logic [3:0]  rq_cmd;
    logic        cp_valid = 1'b0;
    logic [15:0] cp_id = '0;
    logic        cp_tag = 1'b0;
    logic [12:0] cp_bytes = '0;
    logic [31:0] cp_data = '0;
    logic        cp_devsel;
    logic        cd_valid;
    logic        cd_tag;
    logic [31:0] cd_data;
    logic        rt_valid;
    logic        rt_tag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sptag_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .own_id(own_id),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
        .up_len(up_len), .up_cmd(up_cmd), .up_cross_err(up_cross_err),
        .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_bytes(rq_bytes),
        .rq_tag(rq_tag), .rq_cmd(rq_cmd),
        .cp_valid(cp_valid), .cp_id(cp_id), .cp_tag(cp_tag),
        .cp_bytes(cp_bytes), .cp_data(cp_data), .cp_devsel(cp_devsel),
        .cd_valid(cd_valid), .cd_tag(cd_tag), .cd_data(cd_data),
        .rt_valid(rt_valid), .rt_tag(rt_tag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // returns at the falling edge after the accepting edge
    task automatic drive_req(input logic [31:0] a, input logic [9:0] l);
        @(negedge clk);
        while (!up_ready) @(negedge clk);
        up_valid = 1'b1; up_addr = a; up_len = l;
        @(posedge clk);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    // returns at the falling edge after the sampling edge
    task automatic drive_cpl(input logic [15:0] id, input logic t,
                             input logic [12:0] b, input logic [31:0] d);
        @(negedge clk);
        cp_valid = 1'b1; cp_id = id; cp_tag = t; cp_bytes = b; cp_data = d;
        @(posedge clk);
        @(negedge clk);
        cp_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int offs [10] = '{0, 4, 8, 'h400, 'h7FC, 'h800, 'hA00, 'hFF0, 'hFF8, 'hFFC};
        int lens [11] = '{1, 2, 3, 4, 5, 64, 255, 512, 1022, 1023, 0};
        int idx = 0;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 up_ready", up_ready, 1);
        chk("R1 rq_valid", rq_valid, 0);
        chk("R1 devsel", cp_devsel, 0);
        chk("R1 cd_valid", cd_valid, 0);
        chk("R1 rt_valid", rt_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 up_ready after release", up_ready, 1);
        chk("R6 no err at rest", up_cross_err, 0);

        // sweep of offsets and lengths: R3 R5 R6 R4 R10
        foreach (offs[oi]) begin
            foreach (lens[li]) begin
                logic [31:0] base;
                int bytes;
                int room;
                bit sp;
                base  = 32'h8000_0000 | (32'(idx) << 12) | 32'(offs[oi]);
                bytes = (lens[li] == 0) ? 4096 : lens[li] * 4;
                room  = 4096 - offs[oi];
                sp    = bytes > room;
                idx++;
                drive_req(base, 10'(lens[li]));
                chk("R3 rq_valid", rq_valid, 1);
                chk("R5 first addr", rq_addr, base);
                chk("R3 R5 first bytes", rq_bytes, sp ? room : bytes);
                chk("R4 first tag", rq_tag, 0);
                chk("R6 cross flag", up_cross_err, sp);
                chk("R3 cmd", rq_cmd, 4'h6);
                @(negedge clk);
                if (sp) begin
                    chk("R5 second valid", rq_valid, 1);
                    chk("R5 second addr", rq_addr, base + 32'(room));
                    chk("R5 second bytes", rq_bytes, bytes - room);
                    chk("R4 second tag", rq_tag, 1);
                    chk("R6 no flag on second", up_cross_err, 0);
                end else begin
                    chk("R5 single piece", rq_valid, 0);
                end
                drive_cpl(MY_ID, 1'b0, 13'd4, 32'hC0DE_0000 + 32'(idx));
                chk("R10 retire tag0", {rt_valid, rt_tag}, 2'b10);
                chk("R7 data fwd", cd_data, 32'hC0DE_0000 + 32'(idx));
                if (sp) begin
                    drive_cpl(MY_ID, 1'b1, 13'd4, 32'h5A5A_0000);
                    chk("R10 retire tag1", {rt_valid, rt_tag}, 2'b11);
                end
            end
        end

        // fill both tags: R2
        drive_req(32'h1000_0000, 10'd8);
        chk("R4 fill tag0", rq_tag, 0);
        drive_req(32'h1000_1000, 10'd8);
        chk("R4 fill tag1", rq_tag, 1);
        @(negedge clk);
        chk("R2 ready low when full", up_ready, 0);

        // multi-beat on tag0: R7 and R10 no early retire
        drive_cpl(MY_ID, 1'b0, 13'd32, 32'h1111_2222);
        chk("R7 devsel", cp_devsel, 1);
        chk("R7 cd_valid", cd_valid, 1);
        chk("R7 cd_tag", cd_tag, 0);
        chk("R7 cd_data", cd_data, 32'h1111_2222);
        chk("R10 no early retire", rt_valid, 0);
        chk("R2 still full", up_ready, 0);

        // foreign ID: R9
        drive_cpl(OTHER_ID, 1'b1, 13'd4, 32'hDEAD_BEEF);
        chk("R9 no devsel", cp_devsel, 0);
        chk("R9 no data", cd_valid, 0);
        chk("R9 no retire", rt_valid, 0);
        chk("R9 tags untouched", up_ready, 0);

        // final beat of tag0
        drive_cpl(MY_ID, 1'b0, 13'd4, 32'h3333_4444);
        chk("R10 retire valid", rt_valid, 1);
        chk("R10 retire tag", rt_tag, 0);
        chk("R2 ready after free", up_ready, 1);

        // stale tag0 with own ID: R8
        drive_cpl(MY_ID, 1'b0, 13'd4, 32'hBAD0_BAD0);
        chk("R8 devsel on stale", cp_devsel, 1);
        chk("R8 data dropped", cd_valid, 0);
        chk("R8 no retire", rt_valid, 0);
        // tag0 still free and is reused lowest first: R4 R8
        drive_req(32'h2000_0040, 10'd4);
        chk("R4 R8 reuse tag0", rq_tag, 0);
        @(negedge clk);
        chk("R2 full again", up_ready, 0);

        // retire tag1, then split with tag0 busy: hold path R5
        drive_cpl(MY_ID, 1'b1, 13'd4, 32'h0);
        chk("R10 retire tag1", {rt_valid, rt_tag}, 2'b11);
        drive_req(32'h3000_0FF8, 10'd4);
        chk("R5 hold first bytes", rq_bytes, 8);
        chk("R4 hold first tag", rq_tag, 1);
        chk("R6 hold flag", up_cross_err, 1);
        @(negedge clk);
        chk("R5 second waits", rq_valid, 0);
        @(negedge clk);
        chk("R5 still waiting", rq_valid, 0);
        chk("R2 ready low in hold", up_ready, 0);
        drive_cpl(MY_ID, 1'b0, 13'd4, 32'h0);
        chk("R10 free tag0", rt_valid, 1);
        chk("R5 second released", rq_valid, 1);
        chk("R5 second addr", rq_addr, 32'h3000_1000);
        chk("R5 second bytes", rq_bytes, 8);
        chk("R4 second tag0", rq_tag, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule